// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides a system clock into time quanta and lays a CAN bit out over them: one synchronisation quantum, a first timing segment that ends at the sample point, and a second timing segment that ends at the bit boundary. It watches the synchronised receive line for recessive-to-dominant transitions. It moves its own sample point toward such an edge by no more than the programmed jump width, so a receiver stays locked to a transmitter whose clock drifts a little. It delivers the sampled bit value with a strobe at each sample point and a second strobe at each bit boundary. A frame decoder downstream consumes these strobes.

All timing comes from one 32-bit configuration word. The word is captured only while the configuration qualifier is high, and the timing engine is held at the start of a bit for as long as the qualifier stays high. Each field holds its value minus one. Triple sampling with a majority vote can be selected, and it is honoured only for long quanta.

Top module: `can_bit_timing`

## Requirements
- R1: While reset is active, and after it is released before any sample point, `sample_stb` and `bit_stb` are 0 and `rx_bit` is 1.
- R2: `cfg_word` is captured only in cycles where `cfg_en` is 1. Changes to `cfg_word` while `cfg_en` is 0 have no effect on timing. While `cfg_en` is 1 no strobe is produced and the engine restarts at the synchronisation quantum.
- R3: Field encoding: bits 23:16 = prescaler P-1, bits 9:8 = jump width SJW-1, bits 6:3 = TSEG1-1, bits 2:0 = TSEG2-1. A quantum lasts P clock cycles. With no falling edge on the line, a bit lasts (1+TSEG1+TSEG2) quanta, so `bit_stb` repeats every P*(1+TSEG1+TSEG2) cycles.
- R4: `sample_stb` pulses for one cycle after the quantum that ends TSEG1, and `rx_bit` takes its new value in that same cycle. `bit_stb` pulses for one cycle after the quantum that ends TSEG2, P*TSEG2 cycles after `sample_stb` when no edge intervenes.
- R5: The line is compared at quantum boundaries. A falling edge found at the end of TSEG1 quantum k (k counted from 0) lengthens TSEG1 by min(k+1, SJW) quanta.
- R6: A falling edge found at the end of TSEG2 quantum k shortens TSEG2 by min(TSEG2-1-k, SJW) quanta. The bit ends on that quantum if it is then past the new end.
- R7: Rising edges, and falling edges found at the end of the synchronisation quantum, cause no adjustment. At most one adjustment is made per bit.
- R8: When bit 7 is 1 and the prescaler field is 4 or more, `rx_bit` is the majority of the line values at the sample point and at the two preceding quantum boundaries.
- R9: When the prescaler field is 3 or less, bit 7 is ignored and `rx_bit` is the single line value at the sample point.
- R10: A falling edge found at the end of the last TSEG1 quantum postpones the sample point: no `sample_stb` appears where it would have, and the sample is taken at the end of the lengthened segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Timing configuration word |
| cfg_en | input | 1 | Configuration mode qualifier; captures `cfg_word` and holds the engine |
| rx_in | input | 1 | Synchronised receive line (1 = recessive) |
| rx_bit | output | 1 | Most recently sampled bit value |
| sample_stb | output | 1 | One-cycle pulse at each sample point |
| bit_stb | output | 1 | One-cycle pulse at each bit boundary |

## Verification
The two functions that collide are resynchronisation and the sample point. A falling edge that lands on the final quantum of the first segment must suppress the sample that would otherwise fire on that same quantum boundary. The bench provokes this by starting the engine from configuration mode with a one-cycle quantum and dropping the line exactly one quantum before the nominal sample point. It then checks that `sample_stb` stays low on the nominal boundary, pulses one quantum later, and carries the dominant value. Free-running transmitters that are slower, faster and irregular also push edges into both segments, and the behavioural model judges every cycle.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   // Field layout of the timing configuration word
   localparam int CFG_W   = 32;
   localparam int T2_LSB  = 0;
   localparam int T2_W    = 3;
   localparam int T1_LSB  = 3;
   localparam int T1_W    = 4;
   localparam int TRI_BIT = 7;
   localparam int SJW_LSB = 8;
   localparam int SJW_W   = 2;
   localparam int PRE_LSB = 16;
   localparam int PRE_W   = 8;

   // Quantum index width: longest first segment plus one jump, plus one
   localparam int QN_W = $clog2((1 << T1_W) + (1 << SJW_W) + 2);

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PH1  = 2'd1,
      SEG_PH2  = 2'd2
   } seg_e;

   typedef struct packed {
      logic [PRE_W-1:0] pre_m1;
      logic [SJW_W-1:0] sjw_m1;
      logic             triple;
      logic [T1_W-1:0]  t1_m1;
      logic [T2_W-1:0]  t2_m1;
   } timing_t;

   function automatic timing_t decode_timing(input logic [CFG_W-1:0] w);
      timing_t t;
      t.pre_m1 = w[PRE_LSB +: PRE_W];
      t.sjw_m1 = w[SJW_LSB +: SJW_W];
      t.triple = w[TRI_BIT];
      t.t1_m1  = w[T1_LSB +: T1_W];
      t.t2_m1  = w[T2_LSB +: T2_W];
      return t;
   endfunction

endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic [PW-1:0] pre_m1,
   output logic          tick
);
   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (hold)            cnt <= '0;
      else if (cnt >= pre_m1)   cnt <= '0;
      else                      cnt <= cnt + PW'(1);
   end

   assign tick = !hold && (cnt >= pre_m1);
endmodule

// File: rtl/cbt_segmenter.sv
module cbt_segmenter
   import can_bt_pkg::*;
#(
   parameter int QW = QN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             tick,
   input  logic             rx_in,
   input  logic [T1_W-1:0]  t1_m1,
   input  logic [T2_W-1:0]  t2_m1,
   input  logic [SJW_W-1:0] sjw_m1,
   output logic             sample_now,
   output logic             bit_end
);
   seg_e          seg;
   logic [QW-1:0] qn;
   logic [QW-1:0] len1;
   logic          prev_q;
   logic          rs_used;

   logic [QW-1:0] t1_len, t2_len, sjw;
   logic [QW-1:0] err1, adj1, len1_eff;
   logic [QW-1:0] err2, adj2, last2;
   logic          fall, do_rs;

   always_comb begin
      t1_len   = QW'(t1_m1) + QW'(1);
      t2_len   = QW'(t2_m1) + QW'(1);
      sjw      = QW'(sjw_m1) + QW'(1);
      fall     = tick && prev_q && !rx_in;
      do_rs    = fall && !rs_used && (seg != SEG_SYNC);
      err1     = qn + QW'(1);
      adj1     = (err1 < sjw) ? err1 : sjw;
      len1_eff = len1 + (do_rs ? adj1 : '0);
      err2     = t2_len - QW'(1) - qn;
      adj2     = (err2 < sjw) ? err2 : sjw;
      last2    = t2_len - QW'(1) - (do_rs ? adj2 : '0);
      sample_now = tick && (seg == SEG_PH1) && (err1 >= len1_eff);
      bit_end    = tick && (seg == SEG_PH2) && (qn >= last2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg     <= SEG_SYNC;
         qn      <= '0;
         len1    <= '0;
         prev_q  <= 1'b1;
         rs_used <= 1'b0;
      end else if (hold) begin
         seg     <= SEG_SYNC;
         qn      <= '0;
         len1    <= '0;
         prev_q  <= 1'b1;
         rs_used <= 1'b0;
      end else if (tick) begin
         prev_q <= rx_in;
         unique case (seg)
            SEG_SYNC: begin
               seg  <= SEG_PH1;
               qn   <= '0;
               len1 <= t1_len;
            end
            SEG_PH1: begin
               if (do_rs) begin
                  len1    <= len1_eff;
                  rs_used <= 1'b1;
               end
               if (sample_now) begin
                  seg <= SEG_PH2;
                  qn  <= '0;
               end else begin
                  qn  <= qn + QW'(1);
               end
            end
            SEG_PH2: begin
               if (bit_end) begin
                  seg     <= SEG_SYNC;
                  qn      <= '0;
                  rs_used <= 1'b0;
               end else begin
                  qn <= qn + QW'(1);
                  if (do_rs) rs_used <= 1'b1;
               end
            end
            default: seg <= SEG_SYNC;
         endcase
      end
   end
endmodule

// File: rtl/cbt_voter.sv
module cbt_voter #(
   parameter bit TRIPLE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic tick,
   input  logic rx_in,
   input  logic sample_now,
   input  logic use_triple,
   output logic rx_bit
);
   logic voted;

   generate
      if (TRIPLE_EN) begin : g_triple
         logic [1:0] hist;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hist <= 2'b11;
            else if (hold)  hist <= 2'b11;
            else if (tick)  hist <= {hist[0], rx_in};
         end
         always_comb begin
            if (use_triple)
               voted = (rx_in & hist[0]) | (rx_in & hist[1]) | (hist[0] & hist[1]);
            else
               voted = rx_in;
         end
      end else begin : g_single
         logic unused_vote_inputs;
         assign unused_vote_inputs = ^{use_triple, tick, hold};
         assign voted = rx_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rx_bit <= 1'b1;
      else if (sample_now) rx_bit <= voted;
   end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
   import can_bt_pkg::*;
#(
   parameter bit TRIPLE_EN      = 1'b1,
   parameter int TRIPLE_MIN_PRE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             cfg_en,
   input  logic             rx_in,
   output logic             rx_bit,
   output logic             sample_stb,
   output logic             bit_stb
);
   localparam logic [PRE_W-1:0] TRI_THR = PRE_W'(TRIPLE_MIN_PRE);

   generate
      if (TRIPLE_MIN_PRE < 0 || TRIPLE_MIN_PRE >= (1 << PRE_W)) begin : g_bad_thr
         $error("TRIPLE_MIN_PRE outside prescaler field range");
      end
      if (PRE_LSB + PRE_W > CFG_W || SJW_LSB + SJW_W > PRE_LSB) begin : g_bad_layout
         $error("configuration fields overlap or exceed the word");
      end
      if (QN_W < T1_W + 1) begin : g_bad_qn
         $error("quantum index too narrow for lengthened segment");
      end
   endgenerate

   timing_t cfg_q;
   logic    unused_rsvd_bits;
   logic    tick, sample_now, bit_end, use_triple;

   assign unused_rsvd_bits = ^{cfg_word[CFG_W-1:PRE_LSB+PRE_W],
                               cfg_word[PRE_LSB-1:SJW_LSB+SJW_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_en) cfg_q <= decode_timing(cfg_word);
   end

   assign use_triple = cfg_q.triple && (cfg_q.pre_m1 >= TRI_THR);

   cbt_prescaler #(.PW(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (cfg_en),
      .pre_m1 (cfg_q.pre_m1),
      .tick   (tick)
   );

   cbt_segmenter u_seg (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (cfg_en),
      .tick       (tick),
      .rx_in      (rx_in),
      .t1_m1      (cfg_q.t1_m1),
      .t2_m1      (cfg_q.t2_m1),
      .sjw_m1     (cfg_q.sjw_m1),
      .sample_now (sample_now),
      .bit_end    (bit_end)
   );

   cbt_voter #(.TRIPLE_EN(TRIPLE_EN)) u_vote (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (cfg_en),
      .tick       (tick),
      .rx_in      (rx_in),
      .sample_now (sample_now),
      .use_triple (use_triple),
      .rx_bit     (rx_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_stb <= 1'b0;
         bit_stb    <= 1'b0;
      end else begin
         sample_stb <= sample_now;
         bit_stb    <= bit_end;
      end
   end
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
   import can_bt_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic             rx_bit,
   input logic             sample_stb,
   input logic             bit_stb,
   input logic [PRE_W-1:0] pre_m1
);
   logic       started;
   logic       pending;
   logic       armed;
   logic [9:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         pending <= 1'b0;
         armed   <= 1'b0;
         gap     <= '0;
      end else begin
         started <= 1'b1;
         if (cfg_en)          pending <= 1'b0;
         else if (sample_stb) pending <= 1'b1;
         else if (bit_stb)    pending <= 1'b0;
         if (cfg_en)                     armed <= 1'b0;
         else if (sample_stb || bit_stb) armed <= 1'b1;
         if (sample_stb || bit_stb) gap <= 10'd1;
         else if (gap != 10'h3FF)   gap <= gap + 10'd1;
      end
   end

   a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && bit_stb));

   a_r2_quiet_in_config: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(cfg_en)) |-> (!sample_stb && !bit_stb));

   a_r4_rx_bit_moves_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ($stable(rx_bit) || sample_stb));

   a_r3_sample_before_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !pending);

   a_r3_boundary_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> pending);

   a_r3_quantum_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (sample_stb || bit_stb)) |-> (gap >= 10'(pre_m1) + 10'd1));
endmodule

bind can_bit_timing cbt_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_en     (cfg_en),
   .rx_bit     (rx_bit),
   .sample_stb (sample_stb),
   .bit_stb    (bit_stb),
   .pre_m1     (cfg_q.pre_m1)
);

// File: tb/can_bit_timing_bench.sv
module can_bit_timing_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_word = 32'h0;
   logic        cfg_en = 1'b0;
   logic        rx_in = 1'b1;
   logic        rx_bit, sample_stb, bit_stb;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   can_bit_timing u_can_bit_timing (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_en(cfg_en),
      .rx_in(rx_in), .rx_bit(rx_bit), .sample_stb(sample_stb), .bit_stb(bit_stb)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_cfg = 32'h0;
   int m_pcnt = 0, m_seg = 0, m_qn = 0, m_len1 = 0;
   bit m_prev = 1, m_rs = 0, m_h0 = 1, m_h1 = 1;
   bit exp_rx = 1, exp_s = 0, exp_b = 0;

   always @(posedge clk) begin
      int pre, t1, t2, sjw, e, lim;
      bit tri_on, tick_now, fall, rs;
      cyc++;
      pre = int'(m_cfg[23:16]);
      t1  = int'(m_cfg[6:3]) + 1;
      t2  = int'(m_cfg[2:0]) + 1;
      sjw = int'(m_cfg[9:8]) + 1;
      tri_on = m_cfg[7] && (pre > 3);
      exp_s = 0;
      exp_b = 0;
      if (!rst_n) begin
         m_cfg = 0; m_pcnt = 0; m_seg = 0; m_qn = 0; m_len1 = 0;
         m_prev = 1; m_rs = 0; m_h0 = 1; m_h1 = 1; exp_rx = 1;
      end else if (cfg_en) begin
         m_cfg = cfg_word; m_pcnt = 0; m_seg = 0; m_qn = 0; m_len1 = 0;
         m_prev = 1; m_rs = 0; m_h0 = 1; m_h1 = 1;
      end else begin
         tick_now = (m_pcnt == pre);
         m_pcnt = tick_now ? 0 : m_pcnt + 1;
         if (tick_now) begin
            fall = m_prev && !rx_in;
            rs = fall && !m_rs && (m_seg != 0);
            if (m_seg == 0) begin
               m_seg = 1; m_qn = 0; m_len1 = t1;
            end else if (m_seg == 1) begin
               if (rs) begin
                  m_len1 += ((m_qn + 1) < sjw) ? (m_qn + 1) : sjw;
                  m_rs = 1;
               end
               if (m_qn + 1 >= m_len1) begin
                  exp_s = 1;
                  exp_rx = tri_on ? ((rx_in + m_h0 + m_h1) >= 2) : rx_in;
                  m_seg = 2; m_qn = 0;
               end else m_qn++;
            end else begin
               e = t2 - 1 - m_qn;
               lim = t2 - 1 - (rs ? ((e < sjw) ? e : sjw) : 0);
               if (m_qn >= lim) begin
                  exp_b = 1; m_seg = 0; m_qn = 0; m_rs = 0;
               end else begin
                  m_qn++;
                  if (rs) m_rs = 1;
               end
            end
            m_h1 = m_h0; m_h0 = rx_in; m_prev = rx_in;
         end
      end
   end

   // ---------------- per-cycle comparison and strobe timestamps ----------------
   int last_b = 0, prev_b = 0, nb = 0, last_s = 0;
   always @(negedge clk) begin
      if (!done) begin
         chk(sample_stb === exp_s, cur_req, "sample_stb", int'(sample_stb), int'(exp_s));
         chk(bit_stb === exp_b, cur_req, "bit_stb", int'(bit_stb), int'(exp_b));
         chk(rx_bit === exp_rx, cur_req, "rx_bit", int'(rx_bit), int'(exp_rx));
         if (sample_stb) last_s = cyc;
         if (bit_stb) begin prev_b = last_b; last_b = cyc; nb++; end
      end
   end

   task automatic program_cfg(input logic [31:0] w);
      @(negedge clk);
      cfg_word = w; cfg_en = 1'b1; rx_in = 1'b1;
      repeat (3) @(negedge clk);
      cfg_en = 1'b0;
   endtask

   task automatic wait_bits(input int n);
      int target;
      target = nb + n;
      while (nb < target) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] lfsr;
      int per, sb;
      lfsr = 16'hACE1;
      // R1: reset state
      repeat (2) @(negedge clk);
      chk(sample_stb === 1'b0 && bit_stb === 1'b0, "R1", "strobes in reset", int'(sample_stb | bit_stb), 0);
      chk(rx_bit === 1'b1, "R1", "rx_bit in reset", int'(rx_bit), 1);
      rst_n = 1'b1;

      // R3 R4: config A, idle line; P=3 TSEG1=5 TSEG2=3 -> 27 cycles per bit
      cur_req = "R3";
      program_cfg(32'h0002_0122);
      wait_bits(3);
      per = last_b - prev_b;
      chk(per == 27, "R3", "bit period A", per, 27);
      sb = last_b - last_s;
      chk(sb == 9, "R4", "sample to boundary A", sb, 9);

      // R2: write while not in configuration mode is ignored
      cur_req = "R2";
      @(negedge clk); cfg_word = 32'h0000_033B;
      wait_bits(3);
      per = last_b - prev_b;
      chk(per == 27, "R2", "period after ignored write", per, 27);

      // R3: config B, P=1 TSEG1=8 TSEG2=4 SJW=4 -> 13 cycles
      cur_req = "R3";
      program_cfg(32'h0000_033B);
      wait_bits(3);
      per = last_b - prev_b;
      chk(per == 13, "R3", "bit period B", per, 13);
      sb = last_b - last_s;
      chk(sb == 4, "R4", "sample to boundary B", sb, 4);

      // R5: slow transmitter, edges late into TSEG1
      cur_req = "R5";
      for (int i = 0; i < 40; i++) begin
         rx_in = i[0];
         repeat (15) @(negedge clk);
      end
      // R6: fast transmitter, edges early in TSEG2
      cur_req = "R6";
      for (int i = 0; i < 40; i++) begin
         rx_in = i[0];
         repeat (11) @(negedge clk);
      end

      // R7: irregular bit lengths, config C (P=2, SJW=1)
      cur_req = "R7";
      program_cfg(32'h0001_0011);
      for (int i = 0; i < 120; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rx_in = lfsr[0];
         repeat (3 + int'(lfsr[3:1])) @(negedge clk);
      end

      // R8: triple sampling honoured (prescaler field 5), noisy line
      cur_req = "R8";
      program_cfg(32'h0005_019A);
      for (int i = 0; i < 1500; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rx_in = lfsr[0];
         @(negedge clk);
      end

      // R9: triple bit ignored (prescaler field 3), noisy line
      cur_req = "R9";
      program_cfg(32'h0003_019A);
      for (int i = 0; i < 1000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rx_in = lfsr[0];
         @(negedge clk);
      end

      // R10: edge on last TSEG1 quantum collides with nominal sample point
      cur_req = "R10";
      program_cfg(32'h0000_0009);     // P=1 TSEG1=2 TSEG2=2 SJW=1
      @(posedge clk);                 // sync quantum ends
      @(posedge clk);                 // TSEG1 quantum 0 ends
      @(negedge clk); rx_in = 1'b0;   // falls during TSEG1 quantum 1
      @(posedge clk);                 // nominal sample point
      @(negedge clk);
      chk(sample_stb === 1'b0, "R10", "no sample at nominal point", int'(sample_stb), 0);
      @(posedge clk);
      @(negedge clk);
      chk(sample_stb === 1'b1, "R10", "sample one quantum later", int'(sample_stb), 1);
      chk(rx_bit === 1'b0, "R10", "sampled dominant", int'(rx_bit), 0);
      repeat (20) @(negedge clk);

      finish_run();
   end
endmodule